// File: doc/BRIEF.md
# Smart LED NRZ Frame Transmitter

This block drives a daisy chain of addressable RGB LEDs over one wire. Pixel words of 24 bits (red in bits 23:16, green in 15:8, blue in 7:0) are written into a 32-entry buffer. Once enabled, the block pops one word per pixel, reorders its colour bytes, and sends every bit as a high pulse followed by a low pulse. The widths of these pulses are programmable clock-cycle counts, so a zero bit and a one bit have different shapes. Each LED in the chain keeps the first 24 bits it receives and passes the rest on.

The transmitter counts the pixels it has sent. When the count reaches the programmed frame length, it holds the line low for a programmable reset period, raises a sticky finish interrupt and clears its own enable. The buffer is refilled in one of two ways. A DMA request/ack pair can be used, or a CPU data-request interrupt. A control bit selects which. If the buffer runs dry before the frame is complete, the line stays low, a sticky underflow flag is raised, and sending resumes as soon as a word arrives.

Top module: `ledtx_top`

## Requirements
- R1: A zero bit drives `led_out` high for `cfg_t0_hi` cycles, then low for `cfg_t0_lo` cycles.
- R2: A one bit drives `led_out` high for `cfg_t1_hi` cycles, then low for `cfg_t1_lo` cycles.
- R3: Each buffered word is sent as exactly 24 bits. When the buffer is not empty, the next word follows with no gap.
- R4: `cfg_order` selects the byte order on the wire: 0 GRB, 1 RGB, 2 RBG, 3 GBR, 4 BRG, 5 BGR, and 6 or 7 as GRB. With `cfg_msb_first`=1 each byte goes out bit 7 first; with 0 it goes out bit 0 first.
- R5: After `cfg_frame_len` pixels, the line stays low for the last bit's low time plus `cfg_reset_len` cycles. `irq_finish` then rises, and `led_en` drops in the same cycle.
- R6: `irq_finish` stays set until `irq_clr` or `soft_rst` is pulsed. `soft_rst` also clears `underflow`.
- R7: The buffer holds 32 words. A write while it is full is dropped.
- R8: With `cfg_dma_en`=1, `dma_req` is high while the block is enabled and the buffer level is below `cfg_refill_lvl`. It is low in the cycle after `dma_ack`.
- R9: With `cfg_dma_en`=0, `irq_cpu_req` follows the same level condition and `dma_req` stays low. The two requests are never high together.
- R10: If the buffer is empty after a pixel in mid-frame, `led_out` stays low and `underflow` is set and held. Sending resumes with the next written word.
- R11: While `led_en` is 0, `led_out` is low. After `en_set`, the first bit starts only once at least one word is buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_set | input | 1 | Pulse: set the enable |
| irq_clr | input | 1 | Pulse: clear the finish interrupt |
| soft_rst | input | 1 | Pulse: clear all interrupt and status flags |
| cfg_dma_en | input | 1 | 1 selects DMA refill, 0 selects CPU refill |
| cfg_order | input | 3 | Colour byte order code |
| cfg_msb_first | input | 1 | Bit order within each byte |
| cfg_t0_hi | input | 8 | High cycles of a zero bit |
| cfg_t0_lo | input | 8 | Low cycles of a zero bit |
| cfg_t1_hi | input | 8 | High cycles of a one bit |
| cfg_t1_lo | input | 8 | Low cycles of a one bit |
| cfg_reset_len | input | 20 | Cycles of the end-of-frame low period |
| cfg_frame_len | input | 16 | Pixels per frame |
| cfg_refill_lvl | input | 6 | Buffer level below which refill is requested |
| wr_valid | input | 1 | Write strobe for the buffer |
| wr_data | input | 24 | Pixel word {R,G,B} |
| dma_req | output | 1 | DMA refill request |
| dma_ack | input | 1 | DMA ack, given with the last word of a burst |
| irq_cpu_req | output | 1 | CPU refill request interrupt |
| irq_finish | output | 1 | Frame-finished interrupt, sticky |
| underflow | output | 1 | Mid-frame buffer starvation, sticky |
| led_en | output | 1 | Current enable state |
| led_out | output | 1 | Serial NRZ output |

## Verification
Any fault in the shift register, the bit index or the byte reordering changes the decoded 24-bit stream of the very pixel in which it occurs. The bench decodes every pixel from the pulse widths, so such a fault is caught within one pixel time. A wrong pulse counter changes a high or low run length by at least one cycle in the first affected bit. A wrong pixel count shows up as an end-of-frame reset that comes early, comes late or is followed by extra pulses. A wrong buffer pointer or level shows up as wrong pixel data or a mistimed refill request, at the latest when the 33rd write is not dropped.

// File: rtl/ledtx_pkg.sv
package ledtx_pkg;

    localparam int PIX_W  = 24;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_WAIT,
        ST_RESET
    } tx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] r;
        logic [BYTE_W-1:0] g;
        logic [BYTE_W-1:0] b;
    } pixel_t;

    function automatic logic [BYTE_W-1:0] flip_byte(logic [BYTE_W-1:0] x);
        logic [BYTE_W-1:0] y;
        for (int i = 0; i < BYTE_W; i++) y[i] = x[BYTE_W-1-i];
        return y;
    endfunction

    // Produce the 24-bit stream in wire order: bit 23 leaves first.
    function automatic logic [PIX_W-1:0] wire_order(pixel_t p, logic [2:0] mode,
                                                    logic msb_first);
        logic [BYTE_W-1:0] b0, b1, b2;
        case (mode)
            3'd1:    {b0, b1, b2} = {p.r, p.g, p.b};
            3'd2:    {b0, b1, b2} = {p.r, p.b, p.g};
            3'd3:    {b0, b1, b2} = {p.g, p.b, p.r};
            3'd4:    {b0, b1, b2} = {p.b, p.r, p.g};
            3'd5:    {b0, b1, b2} = {p.b, p.g, p.r};
            default: {b0, b1, b2} = {p.g, p.r, p.b};
        endcase
        if (!msb_first) begin
            b0 = flip_byte(b0);
            b1 = flip_byte(b1);
            b2 = flip_byte(b2);
        end
        return {b0, b1, b2};
    endfunction

endpackage

// File: rtl/ledtx_fifo.sv
module ledtx_fifo #(
    parameter int DW    = 24,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LVW  = AW + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic [DW-1:0]  din,
    input  logic           pop,
    output logic [DW-1:0]  dout,
    output logic           empty,
    output logic           full,
    output logic [LVW-1:0] level
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign empty   = (level == '0);
    assign full    = (level == LVW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/ledtx_refill.sv
module ledtx_refill #(
    parameter int LVW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           dma_en,
    input  logic [LVW-1:0] level,
    input  logic [LVW-1:0] thresh,
    input  logic           dma_ack,
    output logic           dma_req,
    output logic           cpu_req
);
    logic below;
    assign below = (level < thresh);

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_req <= 1'b0;
            cpu_req <= 1'b0;
        end else begin
            dma_req <= en && dma_en && below && !dma_ack;
            cpu_req <= en && !dma_en && below;
        end
    end
endmodule

// File: rtl/ledtx_serializer.sv
module ledtx_serializer
    import ledtx_pkg::*;
#(
    parameter int CW = 8,
    parameter int RW = 20,
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             fifo_empty,
    input  logic [PIX_W-1:0] fifo_data,
    output logic             fifo_pop,
    input  logic [2:0]       cfg_order,
    input  logic             cfg_msb_first,
    input  logic [CW-1:0]    cfg_t0_hi,
    input  logic [CW-1:0]    cfg_t0_lo,
    input  logic [CW-1:0]    cfg_t1_hi,
    input  logic [CW-1:0]    cfg_t1_lo,
    input  logic [RW-1:0]    cfg_reset_len,
    input  logic [LW-1:0]    cfg_frame_len,
    output logic             led_out,
    output logic             starved,
    output logic             frame_done
);
    localparam int BIT_W = $clog2(PIX_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(PIX_W - 1);

    tx_state_e        state;
    logic [RW-1:0]    cnt;
    logic [PIX_W-1:0] shreg;
    logic [BIT_W-1:0] bit_idx;
    logic [LW-1:0]    pix_cnt;

    logic [PIX_W-1:0] loaded;
    logic             cnt_zero, word_end, frame_end, can_load;
    logic [RW-1:0]    load_hi, next_hi, cur_lo;

    assign loaded    = wire_order(pixel_t'(fifo_data), cfg_order, cfg_msb_first);
    assign load_hi   = loaded[PIX_W-1]   ? RW'(cfg_t1_hi) : RW'(cfg_t0_hi);
    assign next_hi   = shreg[PIX_W-2]    ? RW'(cfg_t1_hi) : RW'(cfg_t0_hi);
    assign cur_lo    = shreg[PIX_W-1]    ? RW'(cfg_t1_lo) : RW'(cfg_t0_lo);
    assign cnt_zero  = (cnt == '0);
    assign word_end  = (state == ST_LOW) && cnt_zero && (bit_idx == LAST_BIT);
    assign frame_end = word_end && (LW'(pix_cnt + 1'b1) == cfg_frame_len);
    assign can_load  = en && !fifo_empty;

    always_comb begin
        fifo_pop = 1'b0;
        if (can_load) begin
            case (state)
                ST_IDLE, ST_WAIT: fifo_pop = 1'b1;
                ST_LOW:           fifo_pop = word_end && !frame_end;
                default:          fifo_pop = 1'b0;
            endcase
        end
    end

    assign led_out    = (state == ST_HIGH);
    assign starved    = (state == ST_WAIT);
    assign frame_done = (state == ST_RESET) && cnt_zero;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            bit_idx <= '0;
            pix_cnt <= '0;
        end else begin
            if (fifo_pop) begin
                shreg   <= loaded;
                bit_idx <= '0;
                cnt     <= load_hi - RW'(1);
                state   <= ST_HIGH;
            end
            case (state)
                ST_IDLE: if (fifo_pop) pix_cnt <= '0;
                ST_HIGH: begin
                    if (cnt_zero) begin
                        cnt   <= cur_lo - RW'(1);
                        state <= ST_LOW;
                    end else begin
                        cnt <= cnt - RW'(1);
                    end
                end
                ST_LOW: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - RW'(1);
                    end else if (bit_idx != LAST_BIT) begin
                        shreg   <= {shreg[PIX_W-2:0], 1'b0};
                        bit_idx <= bit_idx + 1'b1;
                        cnt     <= next_hi - RW'(1);
                        state   <= ST_HIGH;
                    end else if (frame_end) begin
                        cnt   <= cfg_reset_len - RW'(1);
                        state <= ST_RESET;
                    end else begin
                        pix_cnt <= pix_cnt + 1'b1;
                        if (!fifo_pop) state <= ST_WAIT;
                    end
                end
                ST_RESET: begin
                    if (cnt_zero) state <= ST_IDLE;
                    else          cnt   <= cnt - RW'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ledtx_top.sv
module ledtx_top
    import ledtx_pkg::*;
#(
    parameter int CW    = 8,
    parameter int RW    = 20,
    parameter int LW    = 16,
    parameter int DEPTH = 32,
    localparam int LVW  = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_set,
    input  logic             irq_clr,
    input  logic             soft_rst,
    input  logic             cfg_dma_en,
    input  logic [2:0]       cfg_order,
    input  logic             cfg_msb_first,
    input  logic [CW-1:0]    cfg_t0_hi,
    input  logic [CW-1:0]    cfg_t0_lo,
    input  logic [CW-1:0]    cfg_t1_hi,
    input  logic [CW-1:0]    cfg_t1_lo,
    input  logic [RW-1:0]    cfg_reset_len,
    input  logic [LW-1:0]    cfg_frame_len,
    input  logic [LVW-1:0]   cfg_refill_lvl,
    input  logic             wr_valid,
    input  logic [PIX_W-1:0] wr_data,
    output logic             dma_req,
    input  logic             dma_ack,
    output logic             irq_cpu_req,
    output logic             irq_finish,
    output logic             underflow,
    output logic             led_en,
    output logic             led_out
);
    logic             f_empty, f_full, f_pop;
    logic [PIX_W-1:0] f_data;
    logic [LVW-1:0]   f_level;
    logic             starved, frame_done;

    ledtx_fifo #(.DW(PIX_W), .DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst(rst), .push(wr_valid), .din(wr_data), .pop(f_pop),
        .dout(f_data), .empty(f_empty), .full(f_full), .level(f_level)
    );

    ledtx_serializer #(.CW(CW), .RW(RW), .LW(LW)) i_ser (
        .clk(clk), .rst(rst), .en(led_en), .fifo_empty(f_empty),
        .fifo_data(f_data), .fifo_pop(f_pop), .cfg_order(cfg_order),
        .cfg_msb_first(cfg_msb_first), .cfg_t0_hi(cfg_t0_hi),
        .cfg_t0_lo(cfg_t0_lo), .cfg_t1_hi(cfg_t1_hi), .cfg_t1_lo(cfg_t1_lo),
        .cfg_reset_len(cfg_reset_len), .cfg_frame_len(cfg_frame_len),
        .led_out(led_out), .starved(starved), .frame_done(frame_done)
    );

    ledtx_refill #(.LVW(LVW)) i_refill (
        .clk(clk), .rst(rst), .en(led_en), .dma_en(cfg_dma_en),
        .level(f_level), .thresh(cfg_refill_lvl), .dma_ack(dma_ack),
        .dma_req(dma_req), .cpu_req(irq_cpu_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            led_en     <= 1'b0;
            irq_finish <= 1'b0;
            underflow  <= 1'b0;
        end else begin
            if (frame_done)  led_en <= 1'b0;
            else if (en_set) led_en <= 1'b1;

            if (soft_rst || irq_clr) irq_finish <= 1'b0;
            else if (frame_done)     irq_finish <= 1'b1;

            if (soft_rst)     underflow <= 1'b0;
            else if (starved) underflow <= 1'b1;
        end
    end

    // f_full is consumed inside the fifo; it is wired here for visibility only
    logic unused_full;
    assign unused_full = f_full;
endmodule

// File: rtl/ledtx_chk.sv
module ledtx_chk (
    input logic clk,
    input logic rst,
    input logic led_en,
    input logic led_out,
    input logic irq_finish,
    input logic irq_clr,
    input logic soft_rst,
    input logic underflow,
    input logic dma_req,
    input logic dma_ack,
    input logic irq_cpu_req,
    input logic cfg_dma_en
);
    assert_out_needs_en_R11: assert property (@(posedge clk) disable iff (rst)
        led_out |-> led_en);

    assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (rst)
        !led_en |=> !led_out);

    assert_finish_drops_en_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_finish) |-> !led_en);

    assert_finish_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_finish && !irq_clr && !soft_rst) |=> irq_finish);

    assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (underflow && !soft_rst) |=> underflow);

    assert_ack_drops_req_R8: assert property (@(posedge clk) disable iff (rst)
        dma_ack |=> !dma_req);

    assert_dma_mode_only_R8: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> $past(cfg_dma_en));

    assert_cpu_mode_only_R9: assert property (@(posedge clk) disable iff (rst)
        irq_cpu_req |-> !$past(cfg_dma_en));

    assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(dma_req && irq_cpu_req));
endmodule

bind ledtx_top ledtx_chk i_chk (
    .clk(clk), .rst(rst), .led_en(led_en), .led_out(led_out),
    .irq_finish(irq_finish), .irq_clr(irq_clr), .soft_rst(soft_rst),
    .underflow(underflow), .dma_req(dma_req), .dma_ack(dma_ack),
    .irq_cpu_req(irq_cpu_req), .cfg_dma_en(cfg_dma_en)
);

// File: tb/test_ledtx_top.sv
`timescale 1ns/1ps
module test_ledtx_top;
    localparam int T0H = 2, T0L = 5, T1H = 5, T1L = 2, RST = 30;
    localparam int LOCAP = 60;

    logic        clk = 1'b0, rst = 1'b1;
    logic        en_set = 0, irq_clr = 0, soft_rst = 0, cfg_dma_en = 0;
    logic [2:0]  cfg_order = 0;
    logic        cfg_msb_first = 1;
    logic [7:0]  cfg_t0_hi = T0H, cfg_t0_lo = T0L, cfg_t1_hi = T1H, cfg_t1_lo = T1L;
    logic [19:0] cfg_reset_len = RST;
    logic [15:0] cfg_frame_len = 1;
    logic [5:0]  cfg_refill_lvl = 4;
    logic        wr_valid = 0, dma_ack = 0;
    logic [23:0] wr_data = 0;
    logic        dma_req, irq_cpu_req, irq_finish, underflow, led_en, led_out;

    int compared = 0, mismatched = 0;

    always #2.5 clk = ~clk;

    ledtx_top i_ledtx_top (
        .clk(clk), .rst(rst), .en_set(en_set), .irq_clr(irq_clr),
        .soft_rst(soft_rst), .cfg_dma_en(cfg_dma_en), .cfg_order(cfg_order),
        .cfg_msb_first(cfg_msb_first), .cfg_t0_hi(cfg_t0_hi),
        .cfg_t0_lo(cfg_t0_lo), .cfg_t1_hi(cfg_t1_hi), .cfg_t1_lo(cfg_t1_lo),
        .cfg_reset_len(cfg_reset_len), .cfg_frame_len(cfg_frame_len),
        .cfg_refill_lvl(cfg_refill_lvl), .wr_valid(wr_valid), .wr_data(wr_data),
        .dma_req(dma_req), .dma_ack(dma_ack), .irq_cpu_req(irq_cpu_req),
        .irq_finish(irq_finish), .underflow(underflow), .led_en(led_en),
        .led_out(led_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_stream(logic [23:0] px, int mode, bit msb);
        logic [7:0] r, g, b, x, y, z;
        logic [23:0] s;
        r = px[23:16]; g = px[15:8]; b = px[7:0];
        case (mode)
            1: begin x = r; y = g; z = b; end
            2: begin x = r; y = b; z = g; end
            3: begin x = g; y = b; z = r; end
            4: begin x = b; y = r; z = g; end
            5: begin x = b; y = g; z = r; end
            default: begin x = g; y = r; z = b; end
        endcase
        s = {x, y, z};
        if (!msb) begin
            for (int k = 0; k < 3; k++)
                for (int i = 0; i < 8; i++) s[k*8+i] = {x, y, z}[k*8+7-i];
        end
        return s;
    endfunction

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic write_word(input logic [23:0] d, input bit ack);
        wr_valid = 1'b1; wr_data = d; dma_ack = ack;
        @(negedge clk);
        wr_valid = 1'b0; dma_ack = 1'b0;
    endtask

    task automatic capture_bit(output int hi, output int lo);
        while (!led_out) @(negedge clk);
        hi = 0;
        while (led_out) begin hi++; @(negedge clk); end
        lo = 0;
        while (!led_out && !irq_finish && lo < LOCAP) begin lo++; @(negedge clk); end
    endtask

    // Receive one pixel, decode from pulse widths, check timing and data.
    task automatic rx_pixel(input logic [23:0] px, input int mode, input bit msb,
                            input bit last, input bit stall, input string req);
        logic [23:0] exp_s, got;
        int hi, lo, eh, el, bad_hi, bad_lo;
        bit ok;
        exp_s = expect_stream(px, mode, msb);
        got = '0; ok = 1; bad_hi = 0; bad_lo = 0;
        for (int i = 0; i < 24; i++) begin
            capture_bit(hi, lo);
            got[23-i] = (hi == T1H);
            eh = exp_s[23-i] ? T1H : T0H;
            el = exp_s[23-i] ? T1L : T0L;
            if (i == 23 && last) el += RST;
            if (hi != eh || (!(i == 23 && stall) && lo != el)) begin
                if (ok) begin bad_hi = hi; bad_lo = lo; end
                ok = 0;
            end
        end
        check(ok && got == exp_s, req, $sformatf("pixel stream (hi %0d lo %0d at first bad bit)",
              bad_hi, bad_lo), got, exp_s);
    endtask

    task automatic t_reset;
        check(led_out == 0 && led_en == 0, "R11", "idle after reset", {led_en, led_out}, 0);
        check(irq_finish == 0 && underflow == 0, "R6", "flags after reset",
              {irq_finish, underflow}, 0);
        check(dma_req == 0 && irq_cpu_req == 0, "R8", "requests after reset",
              {dma_req, irq_cpu_req}, 0);
    endtask

    task automatic t_basic;
        bit seen_hi;
        cfg_order = 0; cfg_msb_first = 1; cfg_frame_len = 2; cfg_refill_lvl = 0;
        write_word(24'hA53CF0, 0);
        write_word(24'h0F817E, 0);
        seen_hi = 0;
        repeat (20) begin @(negedge clk); if (led_out) seen_hi = 1; end
        check(!seen_hi, "R11", "line stays low while disabled", seen_hi, 0);
        pulse(en_set);
        rx_pixel(24'hA53CF0, 0, 1, 0, 0, "R1 R2 R3 R4");
        rx_pixel(24'h0F817E, 0, 1, 1, 0, "R3 R5");
        check(irq_finish == 1, "R5", "finish irq after reset period", irq_finish, 1);
        check(led_en == 0, "R5", "enable self-cleared", led_en, 0);
        repeat (3) @(negedge clk);
        check(irq_finish == 1, "R6", "finish irq held", irq_finish, 1);
        pulse(irq_clr);
        check(irq_finish == 0, "R6", "finish irq cleared by irq_clr", irq_finish, 0);
    endtask

    task automatic t_orders;
        int modes [6] = '{1, 2, 3, 4, 5, 7};
        logic [23:0] px;
        cfg_frame_len = 1;
        for (int m = 0; m < 6; m++) begin
            cfg_order = 3'(modes[m]);
            cfg_msb_first = m[0];
            px = 24'h12C3_5A ^ {8'(m * 37), 8'(m * 11), 8'(m * 5)};
            write_word(px, 0);
            pulse(en_set);
            rx_pixel(px, modes[m], m[0], 1, 0, "R4");
            check(led_en == 0, "R5", "enable off after order frame", led_en, 0);
            pulse(irq_clr);
        end
    endtask

    task automatic t_underflow;
        cfg_order = 0; cfg_msb_first = 1; cfg_frame_len = 2;
        write_word(24'h00FF00, 0);
        pulse(en_set);
        rx_pixel(24'h00FF00, 0, 1, 0, 1, "R10");
        check(underflow == 1, "R10", "underflow set when starved", underflow, 1);
        check(led_out == 0 && irq_finish == 0, "R10", "line low, no finish while starved",
              {led_out, irq_finish}, 0);
        write_word(24'h800001, 0);
        rx_pixel(24'h800001, 0, 1, 1, 0, "R10");
        check(irq_finish == 1 && underflow == 1, "R10", "frame done, underflow held",
              {irq_finish, underflow}, 3);
        pulse(soft_rst);
        check(irq_finish == 0 && underflow == 0, "R6", "soft reset clears flags",
              {irq_finish, underflow}, 0);
    endtask

    task automatic t_full;
        cfg_order = 1; cfg_msb_first = 1; cfg_frame_len = 33;
        for (int i = 0; i < 33; i++) write_word(24'(i * 24'h010203 + 24'h400000), 0);
        pulse(en_set);
        for (int i = 0; i < 32; i++)
            rx_pixel(24'(i * 24'h010203 + 24'h400000), 1, 1, 0, i == 31, "R7");
        check(underflow == 1 && led_en == 1, "R7", "33rd write dropped, buffer dry",
              {underflow, led_en}, 3);
        write_word(24'hC0FFEE, 0);
        rx_pixel(24'hC0FFEE, 1, 1, 1, 0, "R7");
        check(irq_finish == 1, "R7", "frame of 33 completes", irq_finish, 1);
        pulse(soft_rst);
    endtask

    task automatic t_dma;
        cfg_dma_en = 1; cfg_refill_lvl = 4; cfg_order = 0; cfg_msb_first = 1;
        cfg_frame_len = 8;
        pulse(en_set);
        repeat (3) @(negedge clk);
        check(dma_req == 1 && irq_cpu_req == 0, "R8", "dma request when empty",
              {dma_req, irq_cpu_req}, 2);
        check(led_out == 0, "R11", "no start with empty buffer", led_out, 0);
        fork
            begin
                for (int i = 0; i < 4; i++) write_word(24'h111111 * 24'(i + 1), i == 3);
                check(dma_req == 0, "R8", "request drops after ack", dma_req, 0);
                for (int i = 4; i < 8; i++) write_word(24'h111111 * 24'(i + 1), i == 7);
                repeat (5) @(negedge clk);
                check(dma_req == 0, "R8", "no request above threshold", dma_req, 0);
            end
            begin
                for (int i = 0; i < 8; i++)
                    rx_pixel(24'h111111 * 24'(i + 1), 0, 1, i == 7, 0, "R8 R3");
            end
        join
        check(irq_finish == 1 && led_en == 0, "R5", "dma frame finished",
              {irq_finish, led_en}, 2);
        @(negedge clk);
        check(dma_req == 0, "R8", "request off once disabled", dma_req, 0);
        pulse(irq_clr);
    endtask

    task automatic t_cpu;
        cfg_dma_en = 0; cfg_refill_lvl = 4; cfg_frame_len = 1; cfg_order = 0;
        pulse(en_set);
        repeat (3) @(negedge clk);
        check(irq_cpu_req == 1 && dma_req == 0, "R9", "cpu request when empty",
              {irq_cpu_req, dma_req}, 2);
        fork
            write_word(24'h5A5A5A, 0);
            rx_pixel(24'h5A5A5A, 0, 1, 1, 0, "R9");
        join
        @(negedge clk);
        check(irq_cpu_req == 0 && dma_req == 0, "R9", "cpu request off after frame",
              {irq_cpu_req, dma_req}, 0);
        pulse(irq_clr);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_basic;
        t_orders;
        t_underflow;
        t_full;
        t_dma;
        t_cpu;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule